// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. A one-cycle `start` opens a conversion. The block first raises a single `sample` strobe for an external track-and-hold circuit. It then searches for the result one bit at a time, beginning with the most significant bit.

For each bit the block drives a trial code on `dac_code` to an external DAC. It gives the DAC and the comparator one clock to settle. On the next edge it reads the comparator output `cmp`. When the analog input is at or above the DAC level it keeps the trial bit; otherwise it clears it.

After the last bit the final code appears on `result` together with a one-cycle `done`. `result` then holds that code until the next conversion replaces it. A new `start` is accepted only while the block is idle.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done` and `sample` go to 0, and `result` and `dac_code` go to all zeros.
- R2: A `start` seen at an edge while `busy` is low raises `sample` for exactly one cycle after that edge, and `busy` goes high in the same cycle.
- R3: In the cycle after the `sample` cycle, `dac_code` holds only its most significant bit set (0x80 for N = 8).
- R4: Each trial decides one bit. The bit is kept when `cmp` is 1, meaning the input is at or above the DAC level; when `cmp` is 0 it is cleared. The next trial code is the bits decided so far with the next lower bit set.
- R5: `done` is high for exactly one cycle. It rises N + 1 clock edges after the edge that accepted `start`, and `busy` is low whenever `done` is high.
- R6: With an ideal quantiser on the comparator, `result` equals floor(Vin·2^N / Vref). It saturates at 2^N − 1 for inputs at or above full scale. Codes 0, 1, 0xAA and 0xFF are reached, as is an input lying exactly on a code boundary.
- R7: `result` changes only at the edge that raises `done`. It keeps its value through idle time and through the next conversion until that conversion finishes.
- R8: A `start` that arrives while `busy` is high is ignored. It causes no new `sample` strobe, the running conversion keeps its timing and its code, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, one cycle |
| cmp | input | 1 | Comparator output: 1 when the analog input is at or above the DAC level |
| dac_code | output | N | Trial code driven to the external DAC |
| sample | output | 1 | One-cycle strobe for the track-and-hold |
| result | output | N | Last finished conversion code |
| busy | output | 1 | High from the accepted start until the final decision |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The case hardest to reach from the ports is a second `start` that arrives in the middle of a search. It must leave no trace on the running conversion: no new sample strobe, no shift in the done timing and no second result. The bench injects such a pulse a few trials into a conversion that targets 0xAA. The scoreboard then holds exactly one expected item, so any extra `done` is flagged. The bench also confirms that `sample` and `busy` stay low afterwards. A second delicate point is an input placed exactly on a DAC step. There the at-or-above rule alone decides whether the code comes out one LSB high or low.

// File: rtl/sar_pkg.sv
// Package: shared types for the successive-approximation controller.
// Assumes: one-hot decoding of the state is not needed; a 2-bit code is enough.
package sar_pkg;

    // Phases of one conversion
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/sar_fsm.sv
// Module: sar_fsm
// Sequences one conversion: idle -> sample strobe -> N bit trials -> idle.
// Assumes: `last_trial` is high during the trial cycle of the least
// significant bit. Starts are honoured in idle only.
module sar_fsm
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_trial,
    output logic clear_o,
    output logic arm_o,
    output logic step_o,
    output logic finish_o,
    output logic sample_o,
    output logic busy_o,
    output logic done_o
);

    sar_phase_e phase_q;
    sar_phase_e phase_d;
    logic       done_q;

    // Next-phase decision
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   if (start) phase_d = PH_SAMPLE;
            PH_SAMPLE: phase_d = PH_TRIAL;
            PH_TRIAL:  if (last_trial) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= finish_o;
        end
    end

    // Control strobes to the trial register
    always_comb begin
        clear_o  = (phase_q == PH_IDLE) && start;
        arm_o    = (phase_q == PH_SAMPLE);
        step_o   = (phase_q == PH_TRIAL);
        finish_o = (phase_q == PH_TRIAL) && last_trial;
    end

    // Status outputs
    assign sample_o = (phase_q == PH_SAMPLE);
    assign busy_o   = (phase_q != PH_IDLE);
    assign done_o   = done_q;

endmodule

// File: rtl/sar_trial.sv
// Module: sar_trial
// Holds the decided bits and a one-hot mask that marks the bit under trial.
// Assumes: clear, arm and step are mutually exclusive, and step occurs only
// while the mask is non-zero.
module sar_trial #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         arm,
    input  logic         step,
    input  logic         cmp,
    output logic [N-1:0] code_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] final_code,
    output logic         last_trial
);

    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] code_d;
    logic [N-1:0] mask_d;

    // Per-bit decision: only the bit under trial takes the comparator value
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (clear)
                code_d[i] = 1'b0;
            else if (step && mask_q[i])
                code_d[i] = cmp;
            else
                code_d[i] = code_q[i];
        end
    end

    // Trial mask walks from the top bit downward
    always_comb begin
        if (clear)
            mask_d = '0;
        else if (arm)
            mask_d = TOP_BIT;
        else if (step)
            mask_d = mask_q >> 1;
        else
            mask_d = mask_q;
    end

    // Code and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else begin
            code_q <= code_d;
            mask_q <= mask_d;
        end
    end

    // Code once the current trial is decided, and end-of-search flag
    assign final_code = code_q | (cmp ? mask_q : '0);
    assign last_trial = mask_q[0];

endmodule

// File: rtl/sar_hold.sv
// Module: sar_hold
// Output register for the finished code; loads only on the finishing edge.
// Assumes: load is a single-cycle strobe.
module sar_hold #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    // Hold register
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/sar_ctrl.sv
// Module: sar_ctrl (top)
// Successive-approximation controller: one sample strobe, then N trials, MSB
// first, then a result with a done pulse.
// Assumes: the external DAC and comparator settle within one clock, and cmp
// is synchronous to clk.
module sar_ctrl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp,
    output logic [N-1:0] dac_code,
    output logic         sample,
    output logic [N-1:0] result,
    output logic         busy,
    output logic         done
);

    logic         clear;
    logic         arm;
    logic         step;
    logic         finish;
    logic         last_trial;
    logic [N-1:0] code_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] final_code;

    // Sequencer
    sar_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .last_trial (last_trial),
        .clear_o    (clear),
        .arm_o      (arm),
        .step_o     (step),
        .finish_o   (finish),
        .sample_o   (sample),
        .busy_o     (busy),
        .done_o     (done)
    );

    // Search register
    sar_trial #(.N(N)) u_trial (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .arm        (arm),
        .step       (step),
        .cmp        (cmp),
        .code_q     (code_q),
        .mask_q     (mask_q),
        .final_code (final_code),
        .last_trial (last_trial)
    );

    // Result register
    sar_hold #(.N(N)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (finish),
        .d     (final_code),
        .q     (result)
    );

    // Trial code: decided bits plus the bit under test
    assign dac_code = code_q | mask_q;

endmodule

// File: rtl/sar_ctrl_chk.sv
// Module: sar_ctrl_chk
// Port-level property checks for sar_ctrl, attached with bind.
// Assumes: the checker sees the top-level ports only.
module sar_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         cmp,
    input logic [N-1:0] dac_code,
    input logic         sample,
    input logic [N-1:0] result,
    input logic         busy,
    input logic         done
);

    localparam logic [N-1:0] ONE     = {{(N-1){1'b0}}, 1'b1};
    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] low_bit;
    assign low_bit = dac_code & (~dac_code + ONE);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (sample && busy));

    // R2
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

    // R3
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> (dac_code == TOP_BIT));

    // R4
    trial_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample && !low_bit[0]) |=>
        (dac_code == (($past(cmp) ? $past(dac_code)
                                  : ($past(dac_code) & ~$past(low_bit)))
                      | ($past(low_bit) >> 1))));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !sample);

endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_sar_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmp      (cmp),
    .dac_code (dac_code),
    .sample   (sample),
    .result   (result),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_sar_ctrl.sv
// Bench for sar_ctrl: an ideal quantiser drives cmp, and a scoreboard queue
// holds the expected code and the start time of each conversion.
module tb_sar_ctrl;

    localparam int    N     = 8;
    localparam longint VREF = 256_000;   // full scale in input units
    localparam longint FULL = (64'd1 << N) - 1;
    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp;
    logic [N-1:0] dac_code;
    logic         sample;
    logic [N-1:0] result;
    logic         busy;
    logic         done;

    longint vin = 0;
    int     n_run = 0;
    int     n_fail = 0;
    longint cyc = 0;
    logic [N-1:0] last_res = '0;

    typedef struct { longint code; longint t0; } item_t;
    item_t sb_q[$];

    sar_ctrl #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp(cmp),
        .dac_code(dac_code), .sample(sample), .result(result),
        .busy(busy), .done(done)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    // Edge counter
    always @(posedge clk) cyc <= cyc + 1;

    // Ideal comparator: input at or above the DAC level
    assign cmp = (vin * (64'd1 << N)) >= (longint'(dac_code) * VREF);

    function automatic longint ideal(input longint v);
        longint e;
        e = (v * (64'd1 << N)) / VREF;
        return (e > FULL) ? FULL : e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop and compare on each done
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(result == it.code, "R6", "result", result, it.code);
                check(cyc - it.t0 == N + 2, "R5", "done timing",
                      cyc - it.t0, N + 2);
            end
        end
    end

    // Driver: run one conversion; poke adds a start while busy
    task automatic convert(input longint v, input bit poke);
        longint e;
        e = ideal(v);
        @(negedge clk);
        vin = v;
        start = 1'b1;
        sb_q.push_back('{e, cyc});
        @(negedge clk);
        start = 1'b0;
        check(sample == 1'b1, "R2", "sample strobe", sample, 1);
        check(busy == 1'b1, "R2", "busy", busy, 1);
        @(negedge clk);
        check(dac_code == TOP_BIT, "R3", "first trial", dac_code, TOP_BIT);
        check(sample == 1'b0, "R2", "sample width", sample, 0);
        check(result == last_res, "R7", "held during run", result, last_res);
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(sample == 1'b0, "R8", "no restart strobe", sample, 0);
        end else begin
            @(negedge clk);
            check(dac_code == ((e[N-1:0] & TOP_BIT) | (TOP_BIT >> 1)), "R4",
                  "second trial", dac_code, (e[N-1:0] & TOP_BIT) | (TOP_BIT >> 1));
        end
        while (busy) @(negedge clk);
        last_res = e[N-1:0];
        if (poke) begin
            repeat (3) @(negedge clk);
            check(!busy && !sample, "R8", "idle after run", {busy, sample}, 0);
        end
    endtask

    // Watchdog
    initial begin
        #(200_000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !sample, "R1", "flags in reset",
              {busy, done, sample}, 0);
        check(result == '0, "R1", "result in reset", result, 0);
        check(dac_code == '0, "R1", "dac_code in reset", dac_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        convert(64'd500, 1'b0);              // code 0, R6
        convert(64'd1_500, 1'b0);            // code 1
        convert(64'd170_400, 1'b0);          // code 0xAA
        convert(64'd255_900, 1'b0);          // code 0xFF
        convert(64'd85_000, 1'b0);           // exact boundary -> 0x55, R4
        convert(64'd300_000, 1'b0);          // saturates at 0xFF, R6

        // R7: result holds while idle with a changed input
        vin = 64'd10_000;
        repeat (5) @(negedge clk);
        check(result == last_res, "R7", "idle hold", result, last_res);

        convert(64'd170_000, 1'b1);          // R8 start while busy
        convert(64'd42_300, 1'b0);           // code 0x2A after the poke
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R5", "all results seen", sb_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule